// File: doc/BRIEF.md
# Transfer Length Descriptor Splitter

This block turns one transfer request into a chain of transfer descriptors. A request has three parts: a starting slot in a descriptor table of `SLOTS` entries, a descriptor template, and a byte count. The engine writes as many descriptors as it needs to cover the whole byte count. It writes one table entry per clock through a write port, and the table itself is held outside the block. Every descriptor it writes is linked to the slot that follows it. A separate sequencer uses the result: it marks the final descriptor and then runs the chain.

Short requests fit in a single descriptor counted in 1-byte units. Long requests are split greedily. The engine writes 16-byte-unit descriptors and ends with a 1-byte-unit descriptor for whatever is left. When the table runs out before the bytes do, the engine stops and reports an error code instead of a slot index.

Descriptor field layout, with `CNT_LSB = DESC_W - UNIT_W`:
- Bits [4 +: IDX_W] hold the next-slot link.
- Bits [9:8] hold the unit-size code: `01` means 1-byte units and `11` means 16-byte units.
- Bits [CNT_LSB +: UNIT_W] hold the unit count.
- All other bits come from the template.

Top module: `desc_len_splitter`

## Requirements
- R1: A start with a byte count of zero raises `done` on the clock edge that samples the start. `result` then equals the start slot, no entry is written, and `busy` stays low.
- R2: When the remaining byte count is at most 2^UNIT_W-1, the engine writes one descriptor. Its size code is `01` in bits [9:8], its unit count equals the remaining bytes, and this write ends the request.
- R3: When the remaining byte count is above 2^UNIT_W-1, the engine writes a descriptor with size code `11`. Its unit count is (remaining >> 4) modulo 2^UNIT_W. The remaining count then drops by 16 times that unit count, and the engine goes on to the next slot.
- R4: Every written descriptor keeps each template bit outside the link, size and count fields unchanged.
- R5: The link field of each written descriptor holds its own slot index plus one, modulo `SLOTS`.
- R6: `busy` rises on the edge that samples a non-zero request. The first write appears one clock later. Each further write follows in the next clock to the next consecutive slot.
- R7: `done` is a one-cycle pulse that appears together with the final write. At that point `result` holds that write's slot and `busy` falls.
- R8: If the slot index reaches `SLOTS` while bytes remain, that cycle writes nothing. `done` pulses, `result` is 16'hFFFF, and `busy` falls.
- R9: A `start` pulse while `busy` is high is ignored. The running request's writes and result stay the same.
- R10: After reset, `busy`, `done` and `wr_en` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled only while idle |
| start_slot | input | IDX_W | First table slot to fill |
| tmpl | input | DESC_W | Descriptor template |
| byte_cnt | input | COUNT_W | Bytes to cover |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Final slot written, or 16'hFFFF on table overflow |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | IDX_W | Table write slot |
| wr_data | output | DESC_W | Descriptor to write |

## Verification
The timing rules are as follows:
- A zero-length request produces `done` one edge after the start.
- For a non-zero request, `busy` is visible after the sampling edge. Write k appears k edges after that edge.
- `done` appears together with the final write. In the overflow case, `done` appears one edge after the write to the last slot.

The bench drives inputs and samples every output on the falling edge. It follows the request with its own arithmetic model, one edge at a time, so each write, each `done` and each `result` is compared in exactly the cycle it is due. Lengths are swept across the 1-byte, 16-byte, masked-count and overflow regions, with varied start slots and stray start pulses.

// File: rtl/split_pkg.sv
package split_pkg;
  // unit-size codes placed in descriptor bits [9:8]
  localparam logic [1:0] SZ_1B  = 2'b01;
  localparam logic [1:0] SZ_16B = 2'b11;
  localparam int NXT_LSB = 4;
  localparam int SZ_LSB  = 8;
  localparam int RES_W   = 16;
  localparam logic [RES_W-1:0] RES_ERR = 16'hFFFF;
endpackage

// File: rtl/split_chunk.sv
// Chooses the unit size and count for one descriptor from the remaining bytes.
module split_chunk
  import split_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int UNIT_W  = 15
) (
  input  logic [COUNT_W-1:0] rem,
  output logic [UNIT_W-1:0]  units,
  output logic [1:0]         code,
  output logic [COUNT_W-1:0] rem_next
);
  localparam logic [COUNT_W-1:0] MAXU = COUNT_W'({UNIT_W{1'b1}});

  always_comb begin
    if (rem <= MAXU) begin
      units    = rem[UNIT_W-1:0];
      code     = SZ_1B;
      rem_next = '0;
    end else begin
      units    = rem[UNIT_W+3:4];
      code     = SZ_16B;
      rem_next = rem - COUNT_W'({units, 4'b0000});
    end
  end
endmodule

// File: rtl/split_pack.sv
// Overlays link, size and count fields onto the template.
module split_pack
  import split_pkg::*;
#(
  parameter int DESC_W = 32,
  parameter int IDX_W  = 4,
  parameter int UNIT_W = 15
) (
  input  logic [DESC_W-1:0] tmpl,
  input  logic [IDX_W-1:0]  slot,
  input  logic [UNIT_W-1:0] units,
  input  logic [1:0]        code,
  output logic [DESC_W-1:0] desc
);
  localparam int CNT_LSB = DESC_W - UNIT_W;

  always_comb begin
    desc = tmpl;
    desc[NXT_LSB +: IDX_W]  = IDX_W'(slot + 1'b1);
    desc[SZ_LSB +: 2]       = code;
    desc[CNT_LSB +: UNIT_W] = units;
  end
endmodule

// File: rtl/desc_len_splitter.sv
module desc_len_splitter
  import split_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int DESC_W  = 32,
  parameter int UNIT_W  = 15,
  parameter int COUNT_W = 24,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [IDX_W-1:0]   start_slot,
  input  logic [DESC_W-1:0]  tmpl,
  input  logic [COUNT_W-1:0] byte_cnt,
  output logic               busy,
  output logic               done,
  output logic [RES_W-1:0]   result,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [DESC_W-1:0]  wr_data
);
  localparam logic [IDX_W:0] SLOT_END = (IDX_W+1)'(SLOTS);
  localparam logic [IDX_W:0] SLOT_ONE = (IDX_W+1)'(1);

  logic [IDX_W:0]     slot_q;
  logic [COUNT_W-1:0] rem_q;
  logic [DESC_W-1:0]  tmpl_q;
  logic               busy_q, done_q, wr_en_q;
  logic [RES_W-1:0]   res_q;
  logic [IDX_W-1:0]   wr_addr_q;
  logic [DESC_W-1:0]  wr_data_q;

  logic [UNIT_W-1:0]  units;
  logic [1:0]         code;
  logic [COUNT_W-1:0] rem_nx;
  logic [DESC_W-1:0]  desc;

  split_chunk #(.COUNT_W(COUNT_W), .UNIT_W(UNIT_W)) chunk_i (
    .rem(rem_q), .units(units), .code(code), .rem_next(rem_nx)
  );

  split_pack #(.DESC_W(DESC_W), .IDX_W(IDX_W), .UNIT_W(UNIT_W)) pack_i (
    .tmpl(tmpl_q), .slot(slot_q[IDX_W-1:0]), .units(units), .code(code), .desc(desc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= '0;
      rem_q     <= '0;
      tmpl_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      res_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          slot_q <= {1'b0, start_slot};
          rem_q  <= byte_cnt;
          tmpl_q <= tmpl;
          if (byte_cnt == '0) begin
            done_q <= 1'b1;
            res_q  <= RES_W'(start_slot);
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else if (slot_q == SLOT_END) begin
        done_q <= 1'b1;
        busy_q <= 1'b0;
        res_q  <= RES_ERR;
      end else begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= slot_q[IDX_W-1:0];
        wr_data_q <= desc;
        rem_q     <= rem_nx;
        if (rem_nx == '0) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          res_q  <= RES_W'(slot_q[IDX_W-1:0]);
        end else begin
          slot_q <= slot_q + SLOT_ONE;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign result  = res_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  // R7: completion and activity never overlap
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R6: a write only follows a busy cycle
  assert_write_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));
  // R6: back-to-back writes go to consecutive slots
  assert_slots_consecutive_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == IDX_W'($past(wr_addr) + 1'b1)));
  // R5: link field points to the following slot
  assert_link_next_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[NXT_LSB +: IDX_W] == IDX_W'(wr_addr + 1'b1)));
  // R8: an overflow report carries no write
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_ERR) |-> !wr_en);
  // R2: a 1-byte-unit descriptor never carries zero units
  assert_short_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[SZ_LSB +: 2] == SZ_1B) |-> (wr_data[DESC_W-1 -: UNIT_W] != '0));
  // R9: request inputs are latched only when leaving idle
  assert_tmpl_held_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(tmpl_q));
endmodule

// File: tb/desc_len_splitter_tb_top.sv
module desc_len_splitter_tb_top;
  localparam int SLOTS = 16;
  localparam int UNIT_W = 4;
  localparam int COUNT_W = 12;
  localparam int DESC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] start_slot = '0;
  logic [DESC_W-1:0] tmpl = '0;
  logic [COUNT_W-1:0] byte_cnt = '0;
  logic busy, done, wr_en;
  logic [15:0] result;
  logic [3:0] wr_addr;
  logic [DESC_W-1:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  desc_len_splitter #(.SLOTS(SLOTS), .DESC_W(DESC_W), .UNIT_W(UNIT_W), .COUNT_W(COUNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_slot(start_slot), .tmpl(tmpl),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .result(result),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One request, modelled edge by edge; poke injects a start while busy (R9)
  task automatic run(input int s, input int len, input logic [31:0] tp, input bit poke);
    int slot;
    int rem;
    int units;
    int code;
    int nrem;
    logic [31:0] exp_d;
    start_slot = 4'(s);
    byte_cnt = 12'(len);
    tmpl = tp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    slot = s;
    rem = len;
    if (len == 0) begin
      chk("R1 done", 64'(done), 64'd1);
      chk("R1 result", 64'(result), 64'(s));
      chk("R1 no write", 64'(wr_en), 64'd0);
      chk("R1 busy", 64'(busy), 64'd0);
      @(negedge clk);
      chk("R1 done pulse", 64'(done), 64'd0);
      return;
    end
    chk("R6 busy rises", 64'(busy), 64'd1);
    chk("R6 no early write", 64'(wr_en), 64'd0);
    for (int k = 0; k <= SLOTS; k++) begin
      if (poke && k == 0) begin
        start = 1'b1;
        start_slot = ~4'(s);
        byte_cnt = 12'd7;
        tmpl = ~tp;
      end
      @(negedge clk);
      start = 1'b0;
      if (slot == SLOTS) begin
        chk("R8 no write", 64'(wr_en), 64'd0);
        chk("R8 done", 64'(done), 64'd1);
        chk("R8 result", 64'(result), 64'hFFFF);
        chk("R8 busy", 64'(busy), 64'd0);
        break;
      end
      if (rem <= 15) begin
        units = rem; code = 1; nrem = 0;
      end else begin
        units = (rem >> 4) & 15; code = 3; nrem = rem - units * 16;
      end
      exp_d = (tp & 32'h0FFF_FC0F) | (32'(units) << 28) | (32'(code) << 8)
            | (32'((slot + 1) % SLOTS) << 4);
      chk("R6 write", 64'(wr_en), 64'd1);
      chk(poke ? "R9 addr" : "R6 addr", 64'(wr_addr), 64'(slot));
      chk(code == 1 ? "R2 R4 R5 data" : "R3 R4 R5 data", 64'(wr_data), 64'(exp_d));
      if (nrem == 0) begin
        chk("R7 done", 64'(done), 64'd1);
        chk(poke ? "R9 result" : "R7 result", 64'(result), 64'(slot));
        chk("R7 busy falls", 64'(busy), 64'd0);
        break;
      end
      chk("R7 no early done", 64'(done), 64'd0);
      chk("R6 busy held", 64'(busy), 64'd1);
      slot++;
      rem = nrem;
    end
    @(negedge clk);
    chk("R7 done pulse", 64'(done), 64'd0);
    chk("R6 idle no write", 64'(wr_en), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 wr_en", 64'(wr_en), 64'd0);
    chk("R10 result", 64'(result), 64'd0);
    // sweep lengths across 1-byte, 16-byte, masked and overflow regions
    for (int len = 0; len < 300; len++)
      run((len * 7) % SLOTS, len, 32'hA5C3_5A3C ^ (32'(len) * 32'h0101_0101), (len % 5) == 3);
    // every start slot with long and maximal counts
    for (int s = 0; s < SLOTS; s++) begin
      run(s, 1000, 32'h1234_5678 + 32'(s), 1'b0);
      run(s, 4095, 32'hFFFF_FFFF, s == 2);
      run(s, 255, 32'h0, 1'b0);
      run(s, 0, 32'hDEAD_BEEF, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule